// File: doc/BRIEF.md
# Random Four-State Pulse Selector

This block sits between a random bit source and four emitter drivers, one per transmit state (H, V, D, A). It gathers pairs of fresh random bits into a two-bit select code and, at each transmit slot, fires exactly one of the four state lines for a fixed number of clock cycles. The state that fires is the one the code names.

Two logging lines run alongside the state lines. A reference pulse marks every slot that fired. A data pulse carries the first bit of the pair. A time tagger therefore reads a '1' when both pulses are present and a '0' when only the reference pulse appears. A slot that arrives before two fresh bits are held is skipped: nothing fires, and a pair is never used twice.

The select width, the pulse width and the nominal slot period are parameters. Elaboration checks reject a pulse that would not fit inside a slot.

Top module: `qps_state_pulse_sel`

## Requirements
- R1: While rst_n is low, all state lines, ref_pulse_o and data_pulse_o are low, whatever rnd_vld and slot_en do. A fired pulse has also ended before the first slot after reset. Bits offered during reset are not kept.
- R2: Each pair is built from two consecutive accepted bits, the first becoming s0 and the second s1. The code is {s1,s0}. State line index equals the code: bit 0 is H (code 0), bit 1 is V (code 1), bit 2 is D (code 2), bit 3 is A (code 3).
- R3: No more than one state line is high in any cycle, and exactly one is high whenever ref_pulse_o is high.
- R4: A slot_en sampled while a pair is held starts a pulse on the next cycle. The pulse keeps ref_pulse_o and the chosen state line high for exactly PULSE_W cycles, then all outputs return low.
- R5: data_pulse_o is high only together with ref_pulse_o, and during a pulse it equals s0 of the pair that pulse uses.
- R6: A slot_en sampled with fewer than two fresh bits held produces no pulse. A partly gathered pair is kept and completed by later bits.
- R7: A pair is consumed by the slot that uses it. The next slot fires only after two newer bits are accepted.
- R8: Random bits that arrive while a full pair is already waiting are discarded, so the waiting pair is unchanged.
- R9: A slot_en sampled while a pulse is still high is ignored. It neither lengthens the pulse nor consumes a waiting pair.
- R10: A bit that is valid in the same cycle that a slot consumes a pair becomes s0 of the next pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rnd_bit | input | 1 | Random bit |
| rnd_vld | input | 1 | rnd_bit is valid this cycle |
| slot_en | input | 1 | One-cycle strobe at the transmit slot rate |
| state_pulse_o | output | 2**SEL_W (4) | One-hot state lines, index = select code |
| ref_pulse_o | output | 1 | Reference pulse, high for every fired slot |
| data_pulse_o | output | 1 | Data pulse, high with the reference pulse when s0 is 1 |

## Verification
The hardest case to produce from the ports is a slot strobe that lands on the last cycle of a running pulse while a complete new pair is already waiting. Here the block must neither extend the pulse nor consume the pair. The bench reaches it by feeding two bits during the pulse and timing the extra strobe to its final cycle, then checking that the outputs drop on time and that the next slot still fires the waiting code. A bit that coincides with a consuming slot is set up the same way, by presenting valid data and the strobe in the same cycle. Every code is swept several times with varying idle gaps between slots.

// File: rtl/qps_pkg.sv
package qps_pkg;
   localparam int QPS_NUM_STATES = 4;
   typedef enum logic [1:0] {
      ST_H = 2'd0,
      ST_V = 2'd1,
      ST_D = 2'd2,
      ST_A = 2'd3
   } pol_state_e;
endpackage

// File: rtl/qps_bit_gather.sv
module qps_bit_gather #(
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_i,
   input  logic             bit_vld,
   input  logic             take,
   output logic [SEL_W-1:0] pair_o,
   output logic             full_o
);
   localparam int CW = $clog2(SEL_W + 1);

   logic [CW-1:0]    cnt_q;
   logic [SEL_W-1:0] bits_q;

   assign full_o = (cnt_q == CW'(SEL_W));
   assign pair_o = bits_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         bits_q <= '0;
      end else if (take) begin
         bits_q <= '0;
         if (bit_vld) begin
            bits_q[0] <= bit_i;
            cnt_q     <= CW'(1);
         end else begin
            cnt_q <= '0;
         end
      end else if (bit_vld && !full_o) begin
         for (int i = 0; i < SEL_W; i++) begin
            if (cnt_q == CW'(i)) bits_q[i] <= bit_i;
         end
         cnt_q <= cnt_q + CW'(1);
      end
   end

   // R6: only a complete pair may be taken
   p_take_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> full_o);
   // R7: a taken pair is gone on the next cycle
   p_fresh_r7: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !full_o);
   // R8: a waiting pair is untouched by further bits
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && !take) |=> (full_o && $stable(bits_q)));
endmodule

// File: rtl/qps_pulse_timer.sv
module qps_pulse_timer #(
   parameter int PULSE_W = 4,
   parameter int SEL_W   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [SEL_W-1:0] sel_i,
   output logic             active_o,
   output logic [SEL_W-1:0] sel_o
);
   localparam int TW = (PULSE_W > 1) ? $clog2(PULSE_W) : 1;

   logic [TW-1:0]    left_q;
   logic             active_q;
   logic [SEL_W-1:0] sel_q;

   assign active_o = active_q;
   assign sel_o    = sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         left_q   <= '0;
         sel_q    <= '0;
      end else if (start && !active_q) begin
         active_q <= 1'b1;
         left_q   <= TW'(PULSE_W - 1);
         sel_q    <= sel_i;
      end else if (active_q) begin
         if (left_q == '0) active_q <= 1'b0;
         else              left_q   <= left_q - TW'(1);
      end
   end

   // R4: a pulse begins only from a start request
   p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active_q) |-> $past(start));
   // R4: a pulse with cycles remaining stays high
   p_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && left_q != '0) |=> active_q);
   // R9: the selection cannot change inside a pulse
   p_sel_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      active_q |=> (!active_q || $stable(sel_q)));
endmodule

// File: rtl/qps_onehot_dec.sv
module qps_onehot_dec
   import qps_pkg::*;
#(
   parameter int SEL_W = 2,
   parameter int N_OUT = 4
) (
   input  logic             en,
   input  logic [SEL_W-1:0] sel,
   output logic [N_OUT-1:0] lines
);
   generate
      if (SEL_W == 2 && N_OUT == QPS_NUM_STATES) begin : g_named
         always_comb begin
            lines = '0;
            if (en) begin
               case (pol_state_e'(sel))
                  ST_H:    lines[0] = 1'b1;
                  ST_V:    lines[1] = 1'b1;
                  ST_D:    lines[2] = 1'b1;
                  default: lines[3] = 1'b1;
               endcase
            end
         end
      end else begin : g_shift
         always_comb begin
            lines = '0;
            for (int i = 0; i < N_OUT; i++) begin
               if (en && sel == SEL_W'(i)) lines[i] = 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/qps_state_pulse_sel.sv
module qps_state_pulse_sel #(
   parameter int SEL_W       = 2,
   parameter int PULSE_W     = 4,
   parameter int SLOT_PERIOD = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rnd_bit,
   input  logic                  rnd_vld,
   input  logic                  slot_en,
   output logic [(1<<SEL_W)-1:0] state_pulse_o,
   output logic                  ref_pulse_o,
   output logic                  data_pulse_o
);
   localparam int N_OUT = 1 << SEL_W;

   generate
      if (SEL_W < 1) begin : g_bad_sel
         $error("SEL_W must be at least 1");
      end
      if (PULSE_W < 1 || PULSE_W >= SLOT_PERIOD) begin : g_bad_width
         $error("PULSE_W must lie in 1 .. SLOT_PERIOD-1");
      end
   endgenerate

   logic             pair_full;
   logic [SEL_W-1:0] pair;
   logic             take;
   logic             active;
   logic [SEL_W-1:0] sel_q;

   assign take = slot_en && pair_full && !active;

   qps_bit_gather #(.SEL_W(SEL_W)) u_gather (
      .clk    (clk),
      .rst_n  (rst_n),
      .bit_i  (rnd_bit),
      .bit_vld(rnd_vld),
      .take   (take),
      .pair_o (pair),
      .full_o (pair_full)
   );

   qps_pulse_timer #(.PULSE_W(PULSE_W), .SEL_W(SEL_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (take),
      .sel_i   (pair),
      .active_o(active),
      .sel_o   (sel_q)
   );

   qps_onehot_dec #(.SEL_W(SEL_W), .N_OUT(N_OUT)) u_dec (
      .en   (active),
      .sel  (sel_q),
      .lines(state_pulse_o)
   );

   assign ref_pulse_o  = active;
   assign data_pulse_o = active && sel_q[0];

   // R1: outputs quiet while reset is held
   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_quiet_r1: assert (state_pulse_o == '0 && !ref_pulse_o && !data_pulse_o);
      end
   end
   // R3: never more than one emitter line
   p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(state_pulse_o));
   // R3: exactly one line with every reference pulse
   p_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ref_pulse_o |-> ($countones(state_pulse_o) == 1));
   // R5: data pulse never without reference pulse
   p_data_ref_r5: assert property (@(posedge clk) disable iff (!rst_n)
      data_pulse_o |-> ref_pulse_o);
   // R6: a rising reference pulse follows a slot with a full pair
   p_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ref_pulse_o) |-> ($past(slot_en) && $past(pair_full)));
endmodule

// File: tb/qps_state_pulse_sel_test.sv
module qps_state_pulse_sel_test;
   localparam int W = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rnd_bit = 1'b0;
   logic       rnd_vld = 1'b0;
   logic       slot_en = 1'b0;
   logic [3:0] state_pulse;
   logic       ref_pulse;
   logic       data_pulse;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   qps_state_pulse_sel #(.SEL_W(2), .PULSE_W(W), .SLOT_PERIOD(8)) uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .rnd_bit      (rnd_bit),
      .rnd_vld      (rnd_vld),
      .slot_en      (slot_en),
      .state_pulse_o(state_pulse),
      .ref_pulse_o  (ref_pulse),
      .data_pulse_o (data_pulse)
   );

   function automatic logic [5:0] obs();
      return {data_pulse, ref_pulse, state_pulse};
   endfunction

   function automatic logic [5:0] on_val(input logic [1:0] code);
      logic [3:0] oh;
      oh = 4'd1 << code;
      return {code[0], 1'b1, oh};
   endfunction

   task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", req, act, exp);
      end
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk);
      rnd_bit = b;
      rnd_vld = 1'b1;
      @(negedge clk);
      rnd_vld = 1'b0;
   endtask

   task automatic send_pair(input logic b0, input logic b1);
      send_bit(b0);
      send_bit(b1);
   endtask

   task automatic fire(input string req, input bit fires, input logic [1:0] code);
      @(negedge clk);
      slot_en = 1'b1;
      @(negedge clk);
      slot_en = 1'b0;
      for (int i = 0; i < W; i++) begin
         if (i > 0) @(negedge clk);
         chk(req, obs(), fires ? on_val(code) : 6'd0);
      end
      @(negedge clk);
      chk(req, obs(), 6'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      // R1: held in reset while inputs toggle
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         rnd_vld = 1'b1;
         rnd_bit = 1'b1;
         slot_en = i[0];
         chk("R1", obs(), 6'd0);
      end
      @(negedge clk);
      rnd_vld = 1'b0;
      slot_en = 1'b0;
      rst_n = 1'b1;
      chk("R1", obs(), 6'd0);
      // R1 R6: reset bits not kept, slot skipped
      fire("R1 R6", 0, 2'd0);

      // R2 R3 R4 R5: sweep every code with varying gaps
      for (int rep = 0; rep < 3; rep++) begin
         for (int c = 0; c < 4; c++) begin
            logic [1:0] cc;
            cc = c[1:0];
            send_pair(cc[0], cc[1]);
            repeat (rep) @(negedge clk);
            fire("R2 R3 R4 R5", 1, cc);
         end
      end

      // R6: one bit only, skipped; completed later
      send_bit(1'b0);
      fire("R6", 0, 2'd0);
      send_bit(1'b1);
      fire("R6", 1, 2'd2);
      // R7: pair used up, next slot skipped
      fire("R7", 0, 2'd0);

      // R8: extra bits after a full pair are dropped
      send_pair(1'b1, 1'b1);
      send_pair(1'b0, 1'b0);
      fire("R8", 1, 2'd3);

      // R9: strobe on last pulse cycle with a new pair waiting
      send_pair(1'b0, 1'b1);
      @(negedge clk);
      slot_en = 1'b1;
      @(negedge clk);
      slot_en = 1'b0;
      chk("R9", obs(), on_val(2'd2));
      rnd_bit = 1'b1;
      rnd_vld = 1'b1;
      @(negedge clk);
      chk("R9", obs(), on_val(2'd2));
      rnd_bit = 1'b1;
      @(negedge clk);
      chk("R9", obs(), on_val(2'd2));
      rnd_vld = 1'b0;
      slot_en = 1'b1;
      @(negedge clk);
      slot_en = 1'b0;
      chk("R9", obs(), 6'd0);
      @(negedge clk);
      chk("R9", obs(), 6'd0);
      fire("R9", 1, 2'd3);

      // R10: bit coinciding with the consuming slot starts the next pair
      send_pair(1'b1, 1'b0);
      @(negedge clk);
      slot_en = 1'b1;
      rnd_bit = 1'b1;
      rnd_vld = 1'b1;
      @(negedge clk);
      slot_en = 1'b0;
      rnd_vld = 1'b0;
      for (int i = 0; i < W; i++) begin
         if (i > 0) @(negedge clk);
         chk("R10", obs(), on_val(2'd1));
      end
      @(negedge clk);
      chk("R10", obs(), 6'd0);
      send_bit(1'b1);
      fire("R10", 1, 2'd3);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule